// File: doc/BRIEF.md
# Per-Core Banked Timer Access Router

This block puts one countdown timer and one watchdog counter for each of N processor cores (N from 1 to 4) behind a single register bus. Every access carries a region number, a 5-bit byte offset within that region, the ID of the core that issues it, separate read and write strobes, and 32-bit write data. Read data and the error flag are returned in the same cycle as the strobe. Writes take effect at the next clock edge.

Two alias regions let a core reach its own counters without knowing its number. The router takes the requesting core's ID and turns it into an instance index. The same counters also appear in fixed direct regions, one per instance. A debugger or another core can use those to reach any instance. Each instance drives one interrupt line, and the lines leave the block interleaved by core.

Each counter instance holds four words: a reload value, a live count, a control word and a sticky expiry flag. Once running, it counts down at a rate divided by a programmable prescaler. When it expires it raises its flag, which is also its interrupt. It then either stops at zero or restarts from the reload value.

Top module: `mpt_banked_router`

## Requirements
- R1: Region 0 reaches the timer of the requesting core, which is instance index core*2.
- R2: Region 1 reaches the watchdog of the requesting core, which is instance index core*2+1.
- R3: Region 2+2k reaches timer k and region 3+2k reaches watchdog k, for every core k below N.
- R4: Interrupt bit 2k belongs to timer k and bit 2k+1 belongs to watchdog k.
- R5: An access through region 0 or 1 whose core ID is N or greater has the following effect:
  - `bus_err` goes high.
  - Read data is zero.
  - A write changes nothing.
- R6: An access to region 2+2N or higher has the following effect:
  - `bus_err` stays low.
  - Read data is zero.
  - A write changes nothing.
- R7: Only whole-word accesses are valid. A nonzero value in offset bits [1:0] raises `bus_err`, returns zero and discards the write.
- R8: Reset clears every register of every instance and drops every interrupt.
- R9: The register layout inside an instance is as follows:
  - Byte offset 0x00 holds the reload value. Writing it also loads the count.
  - Byte offset 0x04 holds the count.
  - Byte offset 0x08 is the control word: bit 0 run, bit 1 repeat, bits [15:8] prescale. All other bits read back as zero.
  - Byte offset 0x0C holds the expiry flag in bit 0. Writing 1 to that bit clears it.
  - All other offsets read zero and ignore writes.
- R10: While run is set and the count is nonzero, the count decreases once every prescale+1 clocks. The step from 1 to 0 sets the flag. It then reloads if repeat is set, or stays at 0 otherwise. The flag is the instance's interrupt.
- R11: Turning run on while the count is zero and repeat is set loads the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 4 | Region number |
| bus_off | input | 5 | Byte offset within the region |
| bus_core | input | 2 | ID of the requesting core |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Error response for the current access |
| irq | output | 2*N | Expiry interrupts: timer 0, watchdog 0, timer 1, ... |

## Verification
Two things are hard to reach from the ports.

The first is showing that a rejected access left every instance untouched, because nothing comes back from a discarded write. The bench therefore first writes a distinct reload value into each instance through the direct regions. It then makes the rejected write through a bad-core alias, an unmapped region or a misaligned offset. Afterwards it reads every instance back through both views.

The second is interrupt timing. It is reached by programming a short count and, in one case, a prescaler, and then sampling the interrupt vector in the exact cycles before and after expiry.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int MAX_CORES = 4;
  localparam int MAX_INST  = 2 * MAX_CORES;
  localparam int IDXW      = $clog2(MAX_INST);
  localparam int SELW      = 4;
  localparam int CIDW      = $clog2(MAX_CORES);
  localparam int OFFW      = 5;
  localparam int DW        = 32;
  localparam int PSW       = 8;

  localparam logic [2:0] W_RELOAD = 3'd0;
  localparam logic [2:0] W_COUNT  = 3'd1;
  localparam logic [2:0] W_CTRL   = 3'd2;
  localparam logic [2:0] W_FLAG   = 3'd3;

  typedef struct packed {
    logic [DW-1:0]  reload;
    logic [DW-1:0]  count;
    logic [PSW-1:0] presc;
    logic [PSW-1:0] pre;
    logic           run;
    logic           rep;
    logic           flag;
  } cnt_state_t;
endpackage

// File: rtl/mpt_rst_sync.sv
module mpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/mpt_decode.sv
module mpt_decode
  import mpt_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [SELW-1:0] sel,
  input  logic [CIDW-1:0] core,
  input  logic [OFFW-1:0] off,
  input  logic            rd,
  input  logic            wr,
  output logic            hit,
  output logic            err,
  output logic [IDXW-1:0] idx
);
  localparam logic [CIDW:0]   CORE_LIM = (CIDW+1)'(N);
  localparam logic [SELW-1:0] INST_LIM = SELW'(2 * N);

  logic            acc;
  logic            misal;
  logic            is_alias;
  logic            core_bad;
  logic            in_range;
  logic [SELW-1:0] dsel;

  always_comb begin
    acc      = rd | wr;
    misal    = |off[1:0];
    is_alias = (sel[SELW-1:1] == '0);
    core_bad = ({1'b0, core} >= CORE_LIM);
    dsel     = sel - SELW'(2);
    in_range = is_alias ? !core_bad : (dsel < INST_LIM);
    err      = acc & (misal | (is_alias & core_bad));
    hit      = acc & !misal & in_range;
    // alias: core*2 + (0 timer / 1 watchdog); direct: region-2
    idx      = is_alias ? {core, sel[0]} : dsel[IDXW-1:0];
  end
endmodule

// File: rtl/mpt_countdown.sv
module mpt_countdown
  import mpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  cnt_state_t st;
  cnt_state_t nx;
  logic       active;
  logic       upd;

  assign active = st.run && (st.count != '0);
  assign upd    = wr_en | active;

  always_comb begin
    nx = st;
    if (active) begin
      if (st.pre == '0) begin
        nx.pre = st.presc;
        if (st.count == DW'(1)) begin
          nx.flag  = 1'b1;
          nx.count = st.rep ? st.reload : '0;
        end else begin
          nx.count = st.count - DW'(1);
        end
      end else begin
        nx.pre = st.pre - PSW'(1);
      end
    end
    if (wr_en) begin
      case (word)
        W_RELOAD: begin
          nx.reload = wdata;
          nx.count  = wdata;
          nx.pre    = st.presc;
        end
        W_COUNT: begin
          nx.count = wdata;
          nx.pre   = st.presc;
        end
        W_CTRL: begin
          nx.run   = wdata[0];
          nx.rep   = wdata[1];
          nx.presc = wdata[15:8];
          if (!st.run && wdata[0]) begin
            nx.pre = wdata[15:8];
            if ((st.count == '0) && wdata[1]) nx.count = st.reload;
          end
        end
        W_FLAG:  nx.flag = nx.flag & ~wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= '0;
    else if (upd) st <= nx;
  end

  always_comb begin
    case (word)
      W_RELOAD: rdata = st.reload;
      W_COUNT:  rdata = st.count;
      W_CTRL:   rdata = {16'b0, st.presc, 6'b0, st.rep, st.run};
      W_FLAG:   rdata = {31'b0, st.flag};
      default:  rdata = '0;
    endcase
  end

  assign irq = st.flag;
endmodule

// File: rtl/mpt_banked_router.sv
module mpt_banked_router
  import mpt_pkg::*;
#(
  parameter int N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] bus_sel,
  input  logic [OFFW-1:0] bus_off,
  input  logic [CIDW-1:0] bus_core,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic [2*N-1:0]  irq
);
  localparam int NINST = 2 * N;

  logic            rst_core_n;
  logic            dec_hit;
  logic            dec_err;
  logic [IDXW-1:0] dec_idx;
  logic [DW-1:0]   rd_arr [MAX_INST];

  mpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mpt_decode #(.N(N)) u_dec (
    .sel  (bus_sel),
    .core (bus_core),
    .off  (bus_off),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .hit  (dec_hit),
    .err  (dec_err),
    .idx  (dec_idx)
  );

  for (genvar i = 0; i < MAX_INST; i++) begin : g_inst
    if (i < NINST) begin : g_used
      logic wr_en_i;
      logic irq_i;
      assign wr_en_i = dec_hit & bus_wr & (dec_idx == IDXW'(i));
      mpt_countdown u_cnt (
        .clk   (clk),
        .rst_n (rst_core_n),
        .wr_en (wr_en_i),
        .word  (bus_off[4:2]),
        .wdata (bus_wdata),
        .rdata (rd_arr[i]),
        .irq   (irq_i)
      );
      assign irq[i] = irq_i;
    end else begin : g_none
      assign rd_arr[i] = '0;
    end
  end

  assign bus_rdata = (dec_hit & bus_rd) ? rd_arr[dec_idx] : '0;
  assign bus_err   = dec_err;
endmodule

// File: rtl/mpt_router_chk.sv
module mpt_router_chk
  import mpt_pkg::*;
#(
  parameter int N = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] bus_sel,
  input logic [OFFW-1:0] bus_off,
  input logic [CIDW-1:0] bus_core,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_err,
  input logic [2*N-1:0]  irq
);
  localparam logic [SELW-1:0] LIM  = SELW'(2 + 2 * N);
  localparam logic [CIDW:0]   CLIM = (CIDW+1)'(N);

  p_bad_core_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && (bus_sel < SELW'(2)) && ({1'b0, bus_core} >= CLIM)
     && (bus_off[1:0] == 2'b00)) |-> (bus_err && (bus_rdata == '0)));

  p_err_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ((bus_rdata == '0) && (bus_rd || bus_wr)));

  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_sel >= LIM) && (bus_off[1:0] == 2'b00))
      |-> (!bus_err && (bus_rdata == '0)));

  p_misalign_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && (bus_off[1:0] != 2'b00)) |-> bus_err);

  p_irq_drop_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> (($past(irq) & ~irq) == '0));
endmodule

bind mpt_banked_router mpt_router_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_off   (bus_off),
  .bus_core  (bus_core),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .irq       (irq)
);

// File: tb/mpt_banked_router_test.sv
module mpt_banked_router_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_sel;
  logic [4:0]  bus_off;
  logic [1:0]  bus_core;
  logic        bus_rd;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;

  mpt_banked_router #(.N(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_off(bus_off),
    .bus_core(bus_core), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [3:0]  sel;
    logic [1:0]  core;
    logic [4:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1, 4'd2,  2'd0, 5'h00, 32'h11,       32'h0,   1'b0, 4'd3},  // R3
    '{1'b1, 4'd3,  2'd0, 5'h00, 32'h22,       32'h0,   1'b0, 4'd3},  // R3
    '{1'b1, 4'd4,  2'd0, 5'h00, 32'h33,       32'h0,   1'b0, 4'd3},  // R3
    '{1'b1, 4'd5,  2'd0, 5'h00, 32'h44,       32'h0,   1'b0, 4'd3},  // R3
    '{1'b0, 4'd0,  2'd0, 5'h00, 32'h0,        32'h11,  1'b0, 4'd1},  // R1
    '{1'b0, 4'd1,  2'd0, 5'h00, 32'h0,        32'h22,  1'b0, 4'd2},  // R2
    '{1'b0, 4'd0,  2'd1, 5'h00, 32'h0,        32'h33,  1'b0, 4'd1},  // R1
    '{1'b0, 4'd1,  2'd1, 5'h04, 32'h0,        32'h44,  1'b0, 4'd2},  // R2
    '{1'b0, 4'd0,  2'd2, 5'h00, 32'h0,        32'h0,   1'b1, 4'd5},  // R5
    '{1'b1, 4'd1,  2'd3, 5'h00, 32'h99,       32'h0,   1'b1, 4'd5},  // R5
    '{1'b0, 4'd5,  2'd0, 5'h00, 32'h0,        32'h44,  1'b0, 4'd5},  // R5
    '{1'b0, 4'd1,  2'd1, 5'h00, 32'h0,        32'h44,  1'b0, 4'd5},  // R5
    '{1'b0, 4'd6,  2'd0, 5'h00, 32'h0,        32'h0,   1'b0, 4'd6},  // R6
    '{1'b1, 4'd7,  2'd0, 5'h00, 32'h77,       32'h0,   1'b0, 4'd6},  // R6
    '{1'b1, 4'd9,  2'd0, 5'h00, 32'h77,       32'h0,   1'b0, 4'd6},  // R6
    '{1'b0, 4'd2,  2'd0, 5'h00, 32'h0,        32'h11,  1'b0, 4'd6},  // R6
    '{1'b0, 4'd3,  2'd0, 5'h00, 32'h0,        32'h22,  1'b0, 4'd6},  // R6
    '{1'b1, 4'd0,  2'd1, 5'h04, 32'h55,       32'h0,   1'b0, 4'd1},  // R1
    '{1'b0, 4'd4,  2'd0, 5'h04, 32'h0,        32'h55,  1'b0, 4'd1},  // R1
    '{1'b0, 4'd4,  2'd0, 5'h00, 32'h0,        32'h33,  1'b0, 4'd9},  // R9
    '{1'b1, 4'd3,  2'd0, 5'h08, 32'hFFFF0702, 32'h0,   1'b0, 4'd9},  // R9
    '{1'b0, 4'd3,  2'd0, 5'h08, 32'h0,        32'h702, 1'b0, 4'd9},  // R9
    '{1'b0, 4'd2,  2'd0, 5'h10, 32'h0,        32'h0,   1'b0, 4'd9},  // R9
    '{1'b0, 4'd2,  2'd0, 5'h02, 32'h0,        32'h0,   1'b1, 4'd7},  // R7
    '{1'b1, 4'd2,  2'd0, 5'h01, 32'hAA,       32'h0,   1'b1, 4'd7},  // R7
    '{1'b0, 4'd2,  2'd0, 5'h00, 32'h0,        32'h11,  1'b0, 4'd7},  // R7
    '{1'b0, 4'd15, 2'd0, 5'h00, 32'h0,        32'h0,   1'b0, 4'd6}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives for one cycle, samples mid-cycle.
  task automatic access(input logic wr, input logic [3:0] sel, input logic [1:0] core,
                        input logic [4:0] off, input logic [31:0] wd,
                        output logic [31:0] rd, output logic e);
    bus_wr = wr; bus_rd = ~wr; bus_sel = sel; bus_core = core;
    bus_off = off; bus_wdata = wd;
    #1;
    rd = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [1:0] core,
                        input logic [4:0] off, input logic [31:0] wd);
    logic [31:0] d; logic e;
    access(1'b1, sel, core, off, wd, d, e);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] sel, input logic [1:0] core,
                        input logic [4:0] off, input logic [31:0] exp);
    logic [31:0] d; logic e;
    access(1'b0, sel, core, off, 32'h0, d, e);
    check(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = '0;
    bus_off = '0; bus_core = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: every word of every instance is zero after reset
    for (int s = 2; s < 6; s++)
      for (int w = 0; w < 4; w++)
        rd_chk("R8 reset word", 4'(s), 2'd0, 5'(w * 4), 32'h0);
    #1 check("R8 reset irq", {28'b0, irq}, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VT[i].wr, VT[i].sel, VT[i].core, VT[i].off, VT[i].wd, d, e);
      check($sformatf("R%0d vec%0d err", VT[i].req, i), {31'b0, e}, {31'b0, VT[i].err});
      if (!VT[i].wr)
        check($sformatf("R%0d vec%0d data", VT[i].req, i), d, VT[i].exp);
    end

    // R10/R4: timer 1 repeating, count 3, prescale 0 -> flag after 3 edges
    wr_reg(4'd4, 2'd0, 5'h00, 32'd3);
    wr_reg(4'd4, 2'd0, 5'h08, 32'h3);
    @(negedge clk); @(negedge clk);
    check("R10 before expiry", {28'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 timer1 on bit2", {28'b0, irq}, 32'h4);
    wr_reg(4'd4, 2'd0, 5'h0C, 32'h1);
    check("R9 flag cleared", {28'b0, irq}, 32'h0);
    wr_reg(4'd4, 2'd0, 5'h08, 32'h0);

    // R10: watchdog 0 one-shot, count 2, prescale 1 -> expiry after 4 edges
    wr_reg(4'd3, 2'd0, 5'h04, 32'd2);
    wr_reg(4'd3, 2'd0, 5'h08, 32'h101);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R10 prescaled before expiry", {28'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 watchdog0 on bit1", {28'b0, irq}, 32'h2);
    repeat (3) @(negedge clk);
    rd_chk("R10 one-shot stays zero", 4'd3, 2'd0, 5'h04, 32'h0);
    wr_reg(4'd1, 2'd0, 5'h0C, 32'h1);
    check("R2 alias clear of watchdog0", {28'b0, irq}, 32'h0);

    // R11: start with count zero and repeat set loads the reload value
    wr_reg(4'd1, 2'd1, 5'h04, 32'h0);
    wr_reg(4'd1, 2'd1, 5'h08, 32'h3);
    rd_chk("R11 count loaded on start", 4'd5, 2'd0, 5'h04, 32'h44);
    wr_reg(4'd1, 2'd1, 5'h08, 32'h0);

    // R8: reset in the middle of a run
    wr_reg(4'd2, 2'd0, 5'h08, 32'h1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R8 mid-run reset reload", 4'd2, 2'd0, 5'h00, 32'h0);
    rd_chk("R8 mid-run reset ctrl", 4'd2, 2'd0, 5'h08, 32'h0);
    rd_chk("R8 mid-run reset other core", 4'd5, 2'd0, 5'h00, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule